// File: doc/BRIEF.md
# Memory Transaction Protection Rule Checker

This block is a firewall placed in front of a memory controller. Each transaction it is shown carries a byte address, a source port number, a transaction ID and a secure/non-secure attribute. The block returns an accept or reject verdict one clock later. The verdict comes from a table of twenty programmable rules. Each rule holds:

- a 1 MiB-granular address window,
- an inclusive ID range,
- a ten-bit port mask,
- a two-bit security mask,
- a valid flag,
- a result bit.

Software never writes a rule directly. It fills three staging registers (window, ID range, attributes) through a small register bus. It then writes a command register with a rule index and a store bit, which copies the staging registers into the selected rule. A load bit copies a rule back into the staging registers so that it can be read. When no valid rule matches, a per-port default register decides.

Register selection uses `busSel`:

| busSel | Register | Layout |
|---|---|---|
| 0 | command | index in [4:0], store in bit 5, load in bit 6; reads back the last index in [4:0] |
| 1 | window staging | low bound [11:0], high bound [23:12] |
| 2 | ID staging | low ID [11:0], high ID [23:12] |
| 3 | attribute staging | security mask [1:0], valid [2], port mask [12:3], result [13] |
| 4 | default actions | one bit per port in [9:0] |

Other `busSel` values read as zero and ignore writes.

Top module: `prot_firewall`

## Requirements
- R1: After reset every rule is invalid and every register reads zero. A transaction from any port 0..9 is therefore accepted.
- R2: A write to busSel 0 with bit 5 set copies the window, ID and attribute staging registers into the rule chosen by bits [4:0]. A read of busSel 0 returns the last written index in [4:0].
- R3: A write to busSel 0 with bit 6 set, and bit 5 clear, loads the chosen rule into the three staging registers. The staging registers are then read back through busSel 1, 2 and 3. Staging registers keep 24, 24 and 14 bits.
- R4: A rule's window matches when low <= txnAddr[31:20] <= high, with both bounds inclusive.
- R5: A rule's ID range matches when lowId <= txnId <= highId, with both bounds inclusive.
- R6: A rule matches only if its port-mask bit for txnPort is set. It also needs security-mask bit 0 set for a secure transaction (txnSecure=1), or bit 1 set for a non-secure one.
- R7: A matching valid rule gives its result bit as the verdict, where 0 is accept and 1 is reject. When several valid rules match, the lowest-numbered rule decides.
- R8: If no valid rule matches, bit txnPort of the default register decides, where 1 is reject. A rule with valid=0 never matches. Port numbers 10..15 are always rejected.
- R9: verdictValid is high exactly one cycle after txnValid, and verdictReject is low whenever verdictValid is low.
- R10: A store or load command whose index is 20 or more leaves the rule table and the staging registers unchanged.
- R11: A transaction presented in the same cycle as a store command is judged against the table as it was before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busSel | input | 3 | Register select |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Read data for the selected register (combinational) |
| txnValid | input | 1 | Transaction present this cycle |
| txnAddr | input | 32 | Transaction byte address |
| txnPort | input | 4 | Source port number |
| txnId | input | 12 | Transaction ID |
| txnSecure | input | 1 | 1 = secure transaction, 0 = non-secure |
| verdictValid | output | 1 | Verdict present (one cycle after txnValid) |
| verdictReject | output | 1 | 1 = reject, 0 = accept |

## Verification
A rule store and a transaction lookup can fall in the same cycle, because the table is written at the same edge that registers the verdict. The bench stages a reject-everything rule while the table is otherwise empty and all defaults accept. It then raises the store command and txnValid in one cycle. The verdict from that cycle must be accept, showing the old table was used. A transaction in the next cycle must be rejected, showing the new rule has taken effect.

// File: rtl/fw_pkg.sv
package fw_pkg;

  localparam int RULE_IDX_W = 5;

  typedef enum logic [2:0] {
    REG_CMD  = 3'd0,
    REG_WIN  = 3'd1,
    REG_ID   = 3'd2,
    REG_ATTR = 3'd3,
    REG_DFLT = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic                  wrWin;
    logic                  wrId;
    logic                  wrAttr;
    logic                  store;
    logic                  load;
    logic [RULE_IDX_W-1:0] idx;
  } ctrl_stb_t;

endpackage

// File: rtl/fw_ctrl.sv
module fw_ctrl
  import fw_pkg::*;
#(
  parameter int NUM_RULES = 20,
  parameter int NUM_PORTS = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [2:0]            busSel,
  input  logic [31:0]           busWdata,
  output ctrl_stb_t             stb,
  output logic [RULE_IDX_W-1:0] cmdIdx,
  output logic [NUM_PORTS-1:0]  dfltMask
);

  localparam logic [RULE_IDX_W-1:0] LAST_IDX = RULE_IDX_W'(NUM_RULES - 1);
  localparam int STORE_BIT = RULE_IDX_W;
  localparam int LOAD_BIT  = RULE_IDX_W + 1;

  reg_sel_e sel;
  logic     idxOk;
  logic     cmdWr;

  always_comb begin
    sel   = reg_sel_e'(busSel);
    idxOk = busWdata[RULE_IDX_W-1:0] <= LAST_IDX;
    cmdWr = busWe && (sel == REG_CMD);

    stb.wrWin  = busWe && (sel == REG_WIN);
    stb.wrId   = busWe && (sel == REG_ID);
    stb.wrAttr = busWe && (sel == REG_ATTR);
    stb.store  = cmdWr && busWdata[STORE_BIT] && idxOk;
    stb.load   = cmdWr && busWdata[LOAD_BIT] && !busWdata[STORE_BIT] && idxOk;
    stb.idx    = busWdata[RULE_IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdIdx   <= '0;
      dfltMask <= '0;
    end else begin
      if (cmdWr) cmdIdx <= busWdata[RULE_IDX_W-1:0];
      if (busWe && (sel == REG_DFLT)) dfltMask <= busWdata[NUM_PORTS-1:0];
    end
  end

endmodule

// File: rtl/fw_datapath.sv
module fw_datapath
  import fw_pkg::*;
#(
  parameter int NUM_RULES = 20,
  parameter int NUM_PORTS = 10,
  parameter int ADDR_W    = 32,
  parameter int BOUND_W   = 12,
  parameter int ID_W      = 12,
  parameter int PORT_W    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_stb_t             stb,
  input  logic [31:0]           busWdata,
  input  logic [NUM_PORTS-1:0]  dfltMask,
  input  logic                  txnValid,
  input  logic [ADDR_W-1:0]     txnAddr,
  input  logic [PORT_W-1:0]     txnPort,
  input  logic [ID_W-1:0]       txnId,
  input  logic                  txnSecure,
  output logic [2*BOUND_W-1:0]  stgWin,
  output logic [2*ID_W-1:0]     stgId,
  output logic [NUM_PORTS+3:0]  stgAttr,
  output logic                  verdictValid,
  output logic                  verdictReject
);

  localparam int WIN_W    = 2 * BOUND_W;
  localparam int IDR_W    = 2 * ID_W;
  localparam int ATTR_W   = NUM_PORTS + 4;
  localparam int VAL_BIT  = 2;
  localparam int MASK_LSB = 3;
  localparam int RES_BIT  = MASK_LSB + NUM_PORTS;

  logic [WIN_W-1:0]  ruleWin  [NUM_RULES];
  logic [IDR_W-1:0]  ruleId   [NUM_RULES];
  logic [ATTR_W-1:0] ruleAttr [NUM_RULES];
  logic [NUM_RULES-1:0] hit;

  logic [BOUND_W-1:0]   txnMb;
  logic                 portOk;
  logic [NUM_PORTS-1:0] portHot;

  assign txnMb   = txnAddr[ADDR_W-1 -: BOUND_W];
  assign portOk  = txnPort < PORT_W'(NUM_PORTS);
  assign portHot = portOk ? (NUM_PORTS'(1) << txnPort) : '0;

  // staging registers: bus writes or load from the table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgWin  <= '0;
      stgId   <= '0;
      stgAttr <= '0;
    end else if (stb.load) begin
      stgWin  <= ruleWin[stb.idx];
      stgId   <= ruleId[stb.idx];
      stgAttr <= ruleAttr[stb.idx];
    end else begin
      if (stb.wrWin)  stgWin  <= busWdata[WIN_W-1:0];
      if (stb.wrId)   stgId   <= busWdata[IDR_W-1:0];
      if (stb.wrAttr) stgAttr <= busWdata[ATTR_W-1:0];
    end
  end

  genvar r;
  generate
    for (r = 0; r < NUM_RULES; r++) begin : g_rule
      logic winHit, idHit, portHit, secHit;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          ruleWin[r]  <= '0;
          ruleId[r]   <= '0;
          ruleAttr[r] <= '0;
        end else if (stb.store && (stb.idx == RULE_IDX_W'(r))) begin
          ruleWin[r]  <= stgWin;
          ruleId[r]   <= stgId;
          ruleAttr[r] <= stgAttr;
        end
      end

      always_comb begin
        winHit  = (txnMb >= ruleWin[r][BOUND_W-1:0]) &&
                  (txnMb <= ruleWin[r][WIN_W-1:BOUND_W]);
        idHit   = (txnId >= ruleId[r][ID_W-1:0]) &&
                  (txnId <= ruleId[r][IDR_W-1:ID_W]);
        portHit = |(ruleAttr[r][MASK_LSB +: NUM_PORTS] & portHot);
        secHit  = txnSecure ? ruleAttr[r][0] : ruleAttr[r][1];
        hit[r]  = ruleAttr[r][VAL_BIT] && winHit && idHit && portHit && secHit;
      end
    end
  endgenerate

  logic anyHit, hitResult, decision;

  always_comb begin
    anyHit    = 1'b0;
    hitResult = 1'b0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        anyHit    = 1'b1;
        hitResult = ruleAttr[i][RES_BIT];
      end
    end
    if (anyHit) decision = hitResult;
    else        decision = !portOk || (|(dfltMask & portHot));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verdictValid  <= 1'b0;
      verdictReject <= 1'b0;
    end else begin
      verdictValid  <= txnValid;
      verdictReject <= txnValid && decision;
    end
  end

endmodule

// File: rtl/prot_firewall.sv
module prot_firewall
  import fw_pkg::*;
#(
  parameter int NUM_RULES = 20,
  parameter int NUM_PORTS = 10,
  parameter int ADDR_W    = 32,
  parameter int BOUND_W   = 12,
  parameter int ID_W      = 12,
  parameter int PORT_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [2:0]        busSel,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              txnValid,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [PORT_W-1:0] txnPort,
  input  logic [ID_W-1:0]   txnId,
  input  logic              txnSecure,
  output logic              verdictValid,
  output logic              verdictReject
);

  ctrl_stb_t                stb;
  logic [RULE_IDX_W-1:0]    cmdIdx;
  logic [NUM_PORTS-1:0]     dfltMask;
  logic [2*BOUND_W-1:0]     stgWin;
  logic [2*ID_W-1:0]        stgId;
  logic [NUM_PORTS+3:0]     stgAttr;

  fw_ctrl #(.NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busSel(busSel),
    .busWdata(busWdata), .stb(stb), .cmdIdx(cmdIdx), .dfltMask(dfltMask)
  );

  fw_datapath #(
    .NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
    .BOUND_W(BOUND_W), .ID_W(ID_W), .PORT_W(PORT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .dfltMask(dfltMask), .txnValid(txnValid), .txnAddr(txnAddr),
    .txnPort(txnPort), .txnId(txnId), .txnSecure(txnSecure),
    .stgWin(stgWin), .stgId(stgId), .stgAttr(stgAttr),
    .verdictValid(verdictValid), .verdictReject(verdictReject)
  );

  always_comb begin
    case (reg_sel_e'(busSel))
      REG_CMD:  busRdata = 32'(cmdIdx);
      REG_WIN:  busRdata = 32'(stgWin);
      REG_ID:   busRdata = 32'(stgId);
      REG_ATTR: busRdata = 32'(stgAttr);
      REG_DFLT: busRdata = 32'(dfltMask);
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/fw_checker.sv
module fw_checker
  import fw_pkg::*;
#(
  parameter int NUM_RULES = 20,
  parameter int NUM_PORTS = 10,
  parameter int PORT_W    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              txnValid,
  input logic [PORT_W-1:0] txnPort,
  input logic              verdictValid,
  input logic              verdictReject,
  input ctrl_stb_t         stb
);

  a_r9_valid_next: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |=> verdictValid);

  a_r9_idle_next: assert property (@(posedge clk) disable iff (!rstN)
    !txnValid |=> (!verdictValid && !verdictReject));

  a_r8_bad_port: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && (int'(txnPort) >= NUM_PORTS)) |=> verdictReject);

  a_r10_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    (stb.store || stb.load) |-> (int'(stb.idx) < NUM_RULES));

  a_r3_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrWin, stb.wrId, stb.wrAttr, stb.store, stb.load}));

endmodule

bind prot_firewall fw_checker #(
  .NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)
) u_fw_checker (
  .clk(clk), .rstN(rstN), .txnValid(txnValid), .txnPort(txnPort),
  .verdictValid(verdictValid), .verdictReject(verdictReject), .stb(stb)
);

// File: tb/test_prot_firewall.sv
module test_prot_firewall;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busSel = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txnValid = 1'b0;
  logic [31:0] txnAddr = '0;
  logic [3:0]  txnPort = '0;
  logic [11:0] txnId = '0;
  logic        txnSecure = 1'b0;
  logic        verdictValid;
  logic        verdictReject;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prot_firewall i_prot_firewall (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busSel(busSel),
    .busWdata(busWdata), .busRdata(busRdata), .txnValid(txnValid),
    .txnAddr(txnAddr), .txnPort(txnPort), .txnId(txnId),
    .txnSecure(txnSecure), .verdictValid(verdictValid),
    .verdictReject(verdictReject)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busSel = sel; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    busSel = sel;
    #1 d = busRdata;
  endtask

  function automatic logic [31:0] mkWin(input logic [11:0] lo, input logic [11:0] hi);
    return {8'h0, hi, lo};
  endfunction

  function automatic logic [31:0] mkAttr(input logic [1:0] sec, input logic vld,
                                          input logic [9:0] mask, input logic res);
    return {18'h0, res, mask, vld, sec};
  endfunction

  task automatic programRule(input int idx, input logic [31:0] w,
                             input logic [31:0] id, input logic [31:0] a);
    busWrite(3'd1, w);
    busWrite(3'd2, id);
    busWrite(3'd3, a);
    busWrite(3'd0, 32'(idx) | 32'h20);
  endtask

  task automatic clearAll();
    busWrite(3'd1, 0);
    busWrite(3'd2, 0);
    busWrite(3'd3, 0);
    for (int k = 0; k < 20; k++) busWrite(3'd0, 32'(k) | 32'h20);
    busWrite(3'd4, 0);
  endtask

  task automatic txn(input string tag, input logic [31:0] a, input logic [3:0] p,
                     input logic [11:0] id, input logic sec, input logic expRej);
    @(negedge clk);
    txnValid = 1'b1; txnAddr = a; txnPort = p; txnId = id; txnSecure = sec;
    @(negedge clk);
    txnValid = 1'b0;
    check({tag, " valid"}, 32'(verdictValid), 32'd1);
    check({tag, " reject"}, 32'(verdictReject), 32'(expRej));
  endtask

  localparam logic [31:0] ALL_WIN = 32'h00FFF000;
  localparam logic [31:0] ALL_ID  = 32'h00FFF000;

  task automatic t_reset();
    logic [31:0] d;
    for (int s = 0; s < 5; s++) begin
      busRead(3'(s), d);
      check($sformatf("R1 reg %0d after reset", s), d, 0);
    end
    txn("R1 accept after reset p0", 32'h8000_0000, 4'd0, 12'h5, 1'b0, 1'b0);
    txn("R1 accept after reset p9", 32'h0000_0000, 4'd9, 12'hFFF, 1'b1, 1'b0);
  endtask

  task automatic t_store_load();
    logic [31:0] d;
    programRule(7, mkWin(12'h123, 12'h456), mkWin(12'h0AB, 12'hCDE),
                mkAttr(2'd2, 1'b1, 10'h155, 1'b1));
    busRead(3'd0, d); check("R2 index readback", d, 32'd7);
    busWrite(3'd1, 32'hFFFF_FFFF);
    busRead(3'd1, d); check("R3 window staging width", d, 32'h00FF_FFFF);
    busWrite(3'd2, 0);
    busWrite(3'd3, 32'hFFFF_FFFF);
    busRead(3'd3, d); check("R3 attr staging width", d, 32'h0000_3FFF);
    busWrite(3'd0, 32'd7 | 32'h40);
    busRead(3'd1, d); check("R3 load window", d, mkWin(12'h123, 12'h456));
    busRead(3'd2, d); check("R3 load id", d, mkWin(12'h0AB, 12'hCDE));
    busRead(3'd3, d); check("R3 load attr", d, mkAttr(2'd2, 1'b1, 10'h155, 1'b1));
    clearAll();
  endtask

  task automatic t_window();
    programRule(1, mkWin(12'h010, 12'h01F), ALL_ID, mkAttr(2'd3, 1'b1, 10'h3FF, 1'b1));
    txn("R4 below low", 32'h00FF_FFFF, 4'd0, 12'h0, 1'b1, 1'b0);
    txn("R4 at low", 32'h0100_0000, 4'd0, 12'h0, 1'b1, 1'b1);
    txn("R4 at high", 32'h01FF_FFFF, 4'd0, 12'h0, 1'b1, 1'b1);
    txn("R4 above high", 32'h0200_0000, 4'd0, 12'h0, 1'b1, 1'b0);
    clearAll();
  endtask

  task automatic t_id();
    programRule(4, ALL_WIN, mkWin(12'h100, 12'h1FF), mkAttr(2'd3, 1'b1, 10'h3FF, 1'b1));
    txn("R5 below low id", 32'h0, 4'd1, 12'h0FF, 1'b0, 1'b0);
    txn("R5 at low id", 32'h0, 4'd1, 12'h100, 1'b0, 1'b1);
    txn("R5 at high id", 32'h0, 4'd1, 12'h1FF, 1'b0, 1'b1);
    txn("R5 above high id", 32'h0, 4'd1, 12'h200, 1'b0, 1'b0);
    clearAll();
  endtask

  task automatic t_port_sec();
    programRule(3, ALL_WIN, ALL_ID, mkAttr(2'd1, 1'b1, 10'h010, 1'b1));
    txn("R6 port4 secure", 32'h0, 4'd4, 12'h0, 1'b1, 1'b1);
    txn("R6 port4 nonsecure vs secure-only", 32'h0, 4'd4, 12'h0, 1'b0, 1'b0);
    txn("R6 port5 not in mask", 32'h0, 4'd5, 12'h0, 1'b1, 1'b0);
    programRule(3, ALL_WIN, ALL_ID, mkAttr(2'd2, 1'b1, 10'h010, 1'b1));
    txn("R6 port4 nonsecure", 32'h0, 4'd4, 12'h0, 1'b0, 1'b1);
    txn("R6 port4 secure vs nonsecure-only", 32'h0, 4'd4, 12'h0, 1'b1, 1'b0);
    clearAll();
  endtask

  task automatic t_priority();
    busWrite(3'd4, 32'h3FF);
    programRule(5, ALL_WIN, ALL_ID, mkAttr(2'd3, 1'b1, 10'h3FF, 1'b1));
    programRule(2, ALL_WIN, ALL_ID, mkAttr(2'd3, 1'b1, 10'h3FF, 1'b0));
    txn("R7 lowest rule accepts", 32'h4000_0000, 4'd2, 12'h7, 1'b0, 1'b0);
    programRule(2, ALL_WIN, ALL_ID, mkAttr(2'd3, 1'b0, 10'h3FF, 1'b0));
    txn("R7 next rule rejects", 32'h4000_0000, 4'd2, 12'h7, 1'b0, 1'b1);
    clearAll();
  endtask

  task automatic t_default();
    busWrite(3'd4, 32'h008);
    txn("R8 default port3 reject", 32'h0, 4'd3, 12'h0, 1'b0, 1'b1);
    txn("R8 default port2 accept", 32'h0, 4'd2, 12'h0, 1'b0, 1'b0);
    txn("R8 port12 rejected", 32'h0, 4'd12, 12'h0, 1'b0, 1'b1);
    busWrite(3'd4, 32'h000);
    programRule(0, ALL_WIN, ALL_ID, mkAttr(2'd3, 1'b0, 10'h3FF, 1'b1));
    txn("R8 invalid rule ignored", 32'h0, 4'd0, 12'h0, 1'b0, 1'b0);
    clearAll();
  endtask

  task automatic t_latency();
    @(negedge clk);
    txnValid = 1'b1; txnAddr = 0; txnPort = 4'd12; txnId = 0; txnSecure = 0;
    #1 check("R9 no verdict in same cycle", 32'(verdictValid), 0);
    @(negedge clk);
    txnValid = 1'b0;
    check("R9 verdict after one cycle", 32'(verdictValid), 1);
    @(negedge clk);
    check("R9 valid drops", 32'(verdictValid), 0);
    check("R9 reject low when idle", 32'(verdictReject), 0);
  endtask

  task automatic t_oob();
    logic [31:0] d;
    programRule(20, ALL_WIN, ALL_ID, mkAttr(2'd3, 1'b1, 10'h3FF, 1'b1));
    txn("R10 store idx 20 ignored", 32'h0, 4'd0, 12'h0, 1'b0, 1'b0);
    busWrite(3'd1, 32'h0055_5555);
    busWrite(3'd0, 32'd25 | 32'h40);
    busRead(3'd1, d); check("R10 load idx 25 ignored", d, 32'h0055_5555);
    busRead(3'd0, d); check("R10 index readback", d, 32'd25);
    clearAll();
  endtask

  task automatic t_same_cycle();
    busWrite(3'd1, ALL_WIN);
    busWrite(3'd2, ALL_ID);
    busWrite(3'd3, mkAttr(2'd3, 1'b1, 10'h3FF, 1'b1));
    @(negedge clk);
    busWe = 1'b1; busSel = 3'd0; busWdata = 32'h20;
    txnValid = 1'b1; txnAddr = 32'h1234_5678; txnPort = 4'd6; txnId = 12'h9; txnSecure = 1'b0;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0; txnValid = 1'b0;
    check("R11 same-cycle uses old table", 32'(verdictReject), 0);
    txn("R11 next cycle uses new rule", 32'h1234_5678, 4'd6, 12'h9, 1'b0, 1'b1);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_store_load();
    t_window();
    t_id();
    t_port_sec();
    t_priority();
    t_default();
    t_latency();
    t_oob();
    t_same_cycle();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule